// File: doc/BRIEF.md
# Boot Image Page Loader

This block sits on the controller side of a processor that is booted and overlaid from a streamed executable image. A request names a memory type (program or data) and an 11-bit page number. The loader then reads image words from a ready/valid stream and looks for section tags. It checks the header word that follows each tag. A section that does not match is skipped. For the matching section, the loader copies the body into the chosen target memory over a write port with one strobe per memory type.

Every location from the header's start offset up to the end of the page gets a write. Body words are written first. The remaining locations are written with zero once the body ends, either at the end of the stream or when the next tag appears. In a boot load of program memory, the word for address zero is held back and written last, because that write releases the target processor from reset.

Top module: `page_loader_top`

## Requirements
- R1: A section starts with a tag word, 24'hFFA001 for program memory or 24'hFFA002 for data memory. The next word is the header: page number in bits [23:13] and start offset in bits [12:0]. A section matches only when its tag type equals the requested type, its page equals the requested page, and its offset is inside the page.
- R2: A section that does not match is skipped. Searching resumes at the next tag word in the stream.
- R3: Body words of the matching section are written to consecutive page addresses, beginning at the start offset. A program load pulses `pm_we` and writes all 24 bits. A data load pulses `dm_we` and writes the low 16 bits.
- R4: When the body ends before the page end, every remaining location up to the last page address is written with zero. The body ends either on the word flagged `img_last` or before a tag word, and that tag word is not consumed.
- R5: After the last page address is written, no further image words are accepted.
- R6: In a boot load of program memory, a write to address 0 is held back and issued as the final write of the load.
- R7: In a program load that is not a boot load, address 0 is written in stream order, so it is the first write when the offset is 0.
- R8: If the stream ends before a matching section is found, `not_found` pulses for one cycle, no target write occurs, and the loader returns to idle. `done` never pulses together with `not_found`.
- R9: At most one strobe is high in any cycle, and a strobe is high only while `tgt_ready` is high. A write held by a low `tgt_ready` is kept and issued later with no loss or change of data.
- R10: After reset, `busy`, `done`, `not_found`, `img_ready` and both strobes are low. `done` pulses for one cycle after the final write, and the loader is idle in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load; taken only when idle |
| req_is_pm | input | 1 | 1 = program memory, 0 = data memory |
| req_page | input | 11 | Requested page number |
| boot_load | input | 1 | Load is a boot load (defers program address 0) |
| img_valid | input | 1 | Image word valid |
| img_data | input | 24 | Image word |
| img_last | input | 1 | Final word of the image stream |
| img_ready | output | 1 | Loader accepts the image word |
| tgt_ready | input | 1 | Target memory can take a write this cycle |
| pm_we | output | 1 | Program memory write strobe |
| dm_we | output | 1 | Data memory write strobe |
| wr_addr | output | PAGE_AW | Page-relative write address |
| pm_wdata | output | 24 | Program memory write data |
| dm_wdata | output | 16 | Data memory write data |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse: page fully written |
| not_found | output | 1 | One-cycle pulse: stream ended without a match |

## Verification
The assertions assume that a body word never equals a tag value. They also assume that `start` is raised only while the loader is idle, and that the stream holds its word steady until it is accepted. The bench builds every image from tag, header and counting body values that stay far from the tag codes. It raises `start` only after the previous load has reported. It advances the stream only on an accepted word. The bench uses a 16-word page, so zero-fill, page-end truncation and the deferred address-zero write can each be checked at every location.

// File: rtl/page_loader_pkg.sv
package page_loader_pkg;
  localparam int IMG_W    = 24;
  localparam int DM_W     = 16;
  localparam int PAGE_W   = 11;
  localparam int OFF_W    = 13;

  typedef enum logic [2:0] {
    LD_IDLE, LD_SEEK, LD_HDR, LD_BODY, LD_FILL, LD_LAST, LD_FLUSH
  } ld_state_e;
endpackage

// File: rtl/pl_hdr_match.sv
module pl_hdr_match
  import page_loader_pkg::*;
#(
  parameter int                PAGE_AW = 13,
  parameter logic [IMG_W-1:0]  TAG_PM  = 24'hFFA001,
  parameter logic [IMG_W-1:0]  TAG_DM  = 24'hFFA002
) (
  input  logic [IMG_W-1:0]   word,
  input  logic               want_pm,
  input  logic [PAGE_W-1:0]  want_page,
  input  logic               sect_pm,
  output logic               is_tag,
  output logic               tag_pm,
  output logic               hdr_ok,
  output logic [PAGE_AW-1:0] hdr_off
);
  logic [OFF_W-1:0] off_full;

  always_comb begin
    off_full = word[OFF_W-1:0];
    tag_pm   = (word == TAG_PM);
    is_tag   = tag_pm || (word == TAG_DM);
    hdr_ok   = (sect_pm == want_pm) &&
               (word[IMG_W-1:OFF_W] == want_page) &&
               ((off_full >> PAGE_AW) == '0);
    hdr_off  = off_full[PAGE_AW-1:0];
  end
endmodule

// File: rtl/pl_wr_port.sv
module pl_wr_port
  import page_loader_pkg::*;
#(
  parameter int PAGE_AW = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic               push_pm,
  input  logic [PAGE_AW-1:0] push_addr,
  input  logic [IMG_W-1:0]   push_data,
  input  logic               tgt_ready,
  output logic               free,
  output logic               pm_we,
  output logic               dm_we,
  output logic [PAGE_AW-1:0] wr_addr,
  output logic [IMG_W-1:0]   wr_data
);
  logic pend, pend_pm;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      pend_pm <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (push) begin
      pend    <= 1'b1;
      pend_pm <= push_pm;
      wr_addr <= push_addr;
      wr_data <= push_data;
    end else if (tgt_ready) begin
      pend    <= 1'b0;
    end
  end

  assign free  = !pend || tgt_ready;
  assign pm_we = pend && pend_pm && tgt_ready;
  assign dm_we = pend && !pend_pm && tgt_ready;
endmodule

// File: rtl/page_loader_top.sv
module page_loader_top
  import page_loader_pkg::*;
#(
  parameter int               PAGE_AW = 13,
  parameter logic [IMG_W-1:0] TAG_PM  = 24'hFFA001,
  parameter logic [IMG_W-1:0] TAG_DM  = 24'hFFA002
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               req_is_pm,
  input  logic [10:0]        req_page,
  input  logic               boot_load,
  input  logic               img_valid,
  input  logic [23:0]        img_data,
  input  logic               img_last,
  output logic               img_ready,
  input  logic               tgt_ready,
  output logic               pm_we,
  output logic               dm_we,
  output logic [PAGE_AW-1:0] wr_addr,
  output logic [23:0]        pm_wdata,
  output logic [15:0]        dm_wdata,
  output logic               busy,
  output logic               done,
  output logic               not_found
);
  ld_state_e          state;
  logic               pm_q, boot_q, sect_pm_q, hold_v;
  logic [PAGE_W-1:0]  page_q;
  logic [PAGE_AW-1:0] cur;
  logic [IMG_W-1:0]   hold_w;

  logic               is_tag, tag_pm, hdr_ok;
  logic [PAGE_AW-1:0] hdr_off;
  logic               free, push, slot, defer;
  logic [PAGE_AW-1:0] push_addr;
  logic [IMG_W-1:0]   push_data, slot_data, wr_data;
  logic               cur_last, take;

  pl_hdr_match #(.PAGE_AW(PAGE_AW), .TAG_PM(TAG_PM), .TAG_DM(TAG_DM)) hdr_i (
    .word(img_data), .want_pm(pm_q), .want_page(page_q), .sect_pm(sect_pm_q),
    .is_tag(is_tag), .tag_pm(tag_pm), .hdr_ok(hdr_ok), .hdr_off(hdr_off)
  );

  pl_wr_port #(.PAGE_AW(PAGE_AW)) wp_i (
    .clk(clk), .rst(rst), .push(push), .push_pm(pm_q), .push_addr(push_addr),
    .push_data(push_data), .tgt_ready(tgt_ready), .free(free),
    .pm_we(pm_we), .dm_we(dm_we), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign pm_wdata = wr_data;
  assign dm_wdata = wr_data[DM_W-1:0];
  assign busy     = (state != LD_IDLE);
  assign cur_last = &cur;
  assign take     = img_valid && img_ready;

  always_comb begin
    img_ready = 1'b0;
    slot      = 1'b0;
    slot_data = '0;
    push_addr = cur;
    push_data = '0;
    push      = 1'b0;
    case (state)
      LD_SEEK, LD_HDR: img_ready = 1'b1;
      LD_BODY: if (!(img_valid && is_tag)) begin
        img_ready = free;
        slot      = img_valid && free;
        slot_data = img_data;
      end
      LD_FILL: slot = free;
      LD_LAST: begin
        push      = free;
        push_addr = '0;
        push_data = hold_w;
      end
      default: ;
    endcase
    defer = slot && boot_q && pm_q && (cur == '0);
    if (slot && !defer) begin
      push      = 1'b1;
      push_data = slot_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LD_IDLE;
      pm_q      <= 1'b0;
      boot_q    <= 1'b0;
      page_q    <= '0;
      sect_pm_q <= 1'b0;
      cur       <= '0;
      hold_v    <= 1'b0;
      hold_w    <= '0;
      done      <= 1'b0;
      not_found <= 1'b0;
    end else begin
      done      <= 1'b0;
      not_found <= 1'b0;
      if (defer) begin
        hold_w <= slot_data;
        hold_v <= 1'b1;
      end
      case (state)
        LD_IDLE: if (start) begin
          pm_q   <= req_is_pm;
          boot_q <= boot_load;
          page_q <= req_page;
          hold_v <= 1'b0;
          state  <= LD_SEEK;
        end
        LD_SEEK: if (take) begin
          if (img_last) begin
            not_found <= 1'b1;
            state     <= LD_IDLE;
          end else if (is_tag) begin
            sect_pm_q <= tag_pm;
            state     <= LD_HDR;
          end
        end
        LD_HDR: if (take) begin
          if (hdr_ok) begin
            cur   <= hdr_off;
            state <= img_last ? LD_FILL : LD_BODY;
          end else if (img_last) begin
            not_found <= 1'b1;
            state     <= LD_IDLE;
          end else begin
            state <= LD_SEEK;
          end
        end
        LD_BODY: begin
          if (img_valid && is_tag) begin
            state <= LD_FILL;
          end else if (slot) begin
            cur <= cur + 1'b1;
            if (cur_last)      state <= (hold_v || defer) ? LD_LAST : LD_FLUSH;
            else if (img_last) state <= LD_FILL;
          end
        end
        LD_FILL: if (slot) begin
          cur <= cur + 1'b1;
          if (cur_last) state <= (hold_v || defer) ? LD_LAST : LD_FLUSH;
        end
        LD_LAST: if (free) state <= LD_FLUSH;
        LD_FLUSH: if (free) begin
          done  <= 1'b1;
          state <= LD_IDLE;
        end
        default: state <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_loader_chk.sv
module page_loader_chk #(
  parameter int PAGE_AW = 13
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               req_is_pm,
  input logic               boot_load,
  input logic               img_ready,
  input logic               tgt_ready,
  input logic               pm_we,
  input logic               dm_we,
  input logic [PAGE_AW-1:0] wr_addr,
  input logic               busy,
  input logic               done,
  input logic               not_found
);
  logic boot_run, zero_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      boot_run  <= 1'b0;
      zero_seen <= 1'b0;
    end else if (start && !busy) begin
      boot_run  <= boot_load && req_is_pm;
      zero_seen <= 1'b0;
    end else if (boot_run && pm_we && wr_addr == '0) begin
      zero_seen <= 1'b1;
    end
  end

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    !(pm_we && dm_we));

  a_r8_no_dual_report: assert property (@(posedge clk) disable iff (rst)
    !(done && not_found));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(pm_we || dm_we || img_ready));

  a_r10_report_idle: assert property (@(posedge clk) disable iff (rst)
    (done || not_found) |-> !busy);

  a_r6_zero_is_last: assert property (@(posedge clk) disable iff (rst)
    zero_seen |-> !(pm_we || dm_we));
endmodule

bind page_loader_top page_loader_chk #(.PAGE_AW(PAGE_AW)) chk_i (
  .clk(clk), .rst(rst), .start(start), .req_is_pm(req_is_pm),
  .boot_load(boot_load), .img_ready(img_ready), .tgt_ready(tgt_ready),
  .pm_we(pm_we), .dm_we(dm_we), .wr_addr(wr_addr), .busy(busy),
  .done(done), .not_found(not_found)
);

// File: tb/page_loader_top_tb_top.sv
module page_loader_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int PW = 1 << AW;
  localparam logic [23:0] T_PM = 24'hFFA001;
  localparam logic [23:0] T_DM = 24'hFFA002;
  localparam logic [23:0] SENT = 24'h5A5A5A;

  logic clk = 1'b0, rst = 1'b1;
  logic start = 1'b0, req_is_pm = 1'b0, boot_load = 1'b0;
  logic [10:0] req_page = '0;
  logic img_valid, img_last, img_ready, tgt_ready;
  logic [23:0] img_data;
  logic pm_we, dm_we, busy, done, not_found;
  logic [AW-1:0] wr_addr;
  logic [23:0] pm_wdata;
  logic [15:0] dm_wdata;

  logic [23:0] stream_w [0:63];
  int n_words = 0, idx;
  logic feeding = 1'b0, clr = 1'b0, stall_mode = 1'b0;
  int rdy_cnt;
  logic [23:0] pm_mem [0:PW-1];
  logic [23:0] dm_mem [0:PW-1];
  int wr_cnt, first_addr, last_addr, bad_strobe;
  int checks = 0, errors = 0, cycles = 0;
  logic saw_done, saw_nf;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_loader_top #(.PAGE_AW(AW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .req_is_pm(req_is_pm),
    .req_page(req_page), .boot_load(boot_load), .img_valid(img_valid),
    .img_data(img_data), .img_last(img_last), .img_ready(img_ready),
    .tgt_ready(tgt_ready), .pm_we(pm_we), .dm_we(dm_we), .wr_addr(wr_addr),
    .pm_wdata(pm_wdata), .dm_wdata(dm_wdata), .busy(busy), .done(done),
    .not_found(not_found)
  );

  assign img_valid = feeding && (idx < n_words);
  assign img_data  = img_valid ? stream_w[idx] : 24'h0;
  assign img_last  = img_valid && (idx == n_words - 1);
  assign tgt_ready = !stall_mode || (rdy_cnt % 3 != 0);

  always @(posedge clk) begin
    cycles  <= cycles + 1;
    rdy_cnt <= rdy_cnt + 1;
    if (clr) begin
      idx <= 0;
      wr_cnt <= 0;
      first_addr <= -1;
      last_addr <= -1;
      bad_strobe <= 0;
      for (int i = 0; i < PW; i++) begin
        pm_mem[i] <= SENT;
        dm_mem[i] <= SENT;
      end
    end else begin
      if (img_valid && img_ready) idx <= idx + 1;
      if ((pm_we || dm_we) && (!tgt_ready || (pm_we && dm_we)))
        bad_strobe <= bad_strobe + 1;
      if (pm_we) pm_mem[wr_addr] <= pm_wdata;
      if (dm_we) dm_mem[wr_addr] <= {8'h00, dm_wdata};
      if (pm_we || dm_we) begin
        wr_cnt <= wr_cnt + 1;
        if (wr_cnt == 0) first_addr <= int'(wr_addr);
        last_addr <= int'(wr_addr);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic add_w(input logic [23:0] w);
    stream_w[n_words] = w;
    n_words++;
  endtask

  function automatic logic [23:0] hdr(input int page, input int off);
    return {11'(page), 13'(off)};
  endfunction

  task automatic new_image();
    @(negedge clk);
    feeding = 1'b0;
    n_words = 0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic run(input bit ispm, input int page, input bit boot);
    req_is_pm = ispm;
    req_page  = 11'(page);
    boot_load = boot;
    start     = 1'b1;
    feeding   = 1'b1;
    saw_done  = 1'b0;
    saw_nf    = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (done) saw_done = 1'b1;
      if (not_found) saw_nf = 1'b1;
      if (saw_done || saw_nf) break;
    end
    if (!saw_done && !saw_nf) chk(1'b0, "timeout", 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rdy_cnt = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !not_found, "R10 idle flags", {busy, done, not_found}, 0);
    chk(!img_ready && !pm_we && !dm_we, "R10 idle port", {img_ready, pm_we, dm_we}, 0);

    // T2: data page 5 from offset 3, short body ending at stream end (R3 R4)
    new_image();
    add_w(T_DM); add_w(hdr(5, 3));
    for (int i = 0; i < 5; i++) add_w(24'h123400 + 24'(i));
    run(1'b0, 5, 1'b0);
    chk(saw_done, "R10 done", saw_done, 1);
    chk(wr_cnt == PW - 3, "R4 write count", wr_cnt, PW - 3);
    for (int a = 0; a < PW; a++) begin
      logic [23:0] e;
      e = (a < 3) ? SENT : (a < 8) ? {8'h00, 16'h3400 + 16'(a - 3)} : 24'h0;
      chk(dm_mem[a] == e, (a < 8) ? "R3 data word" : "R4 zero fill", int'(dm_mem[a]), int'(e));
    end
    chk(pm_mem[0] == SENT, "R3 other strobe idle", int'(pm_mem[0]), int'(SENT));

    // T3: boot PM page 2 at offset 0 after two non-matching sections, stalled target (R1 R2 R5 R6 R9)
    new_image();
    stall_mode = 1'b1;
    add_w(T_PM); add_w(hdr(7, 0));
    for (int i = 0; i < 3; i++) add_w(24'h000100 + 24'(i));
    add_w(T_DM); add_w(hdr(2, 0));
    for (int i = 0; i < 2; i++) add_w(24'h000200 + 24'(i));
    add_w(T_PM); add_w(hdr(2, 0));
    for (int i = 0; i < 20; i++) add_w(24'hA00000 + 24'(i));
    run(1'b1, 2, 1'b1);
    stall_mode = 1'b0;
    chk(saw_done, "R2 done after skips", saw_done, 1);
    for (int a = 0; a < PW; a++)
      chk(pm_mem[a] == 24'hA00000 + 24'(a), "R1 matched section data", int'(pm_mem[a]), int'(24'hA00000 + 24'(a)));
    chk(dm_mem[0] == SENT, "R1 type mismatch skipped", int'(dm_mem[0]), int'(SENT));
    chk(wr_cnt == PW, "R9 no lost writes", wr_cnt, PW);
    chk(last_addr == 0, "R6 address zero last", last_addr, 0);
    chk(first_addr == 1, "R6 first write", first_addr, 1);
    chk(idx == 27, "R5 stops at page end", idx, 27);
    chk(bad_strobe == 0, "R9 strobe gating", bad_strobe, 0);

    // T4: non-boot PM page 9, body cut by next tag (R7 R4)
    new_image();
    add_w(T_PM); add_w(hdr(9, 0));
    for (int i = 0; i < 4; i++) add_w(24'hB00000 + 24'(i));
    add_w(T_DM); add_w(hdr(9, 0)); add_w(24'h000777);
    run(1'b1, 9, 1'b0);
    chk(first_addr == 0, "R7 address zero in order", first_addr, 0);
    chk(last_addr == PW - 1, "R7 last address", last_addr, PW - 1);
    chk(idx == 6, "R4 tag not consumed", idx, 6);
    for (int a = 0; a < PW; a++) begin
      logic [23:0] e;
      e = (a < 4) ? 24'hB00000 + 24'(a) : 24'h0;
      chk(pm_mem[a] == e, "R4 fill after tag", int'(pm_mem[a]), int'(e));
    end

    // T5: requested page absent (R8)
    new_image();
    add_w(T_DM); add_w(hdr(1, 0));
    for (int i = 0; i < 3; i++) add_w(24'h000300 + 24'(i));
    run(1'b0, 2, 1'b0);
    chk(saw_nf && !saw_done, "R8 not found", {saw_nf, saw_done}, 2);
    chk(wr_cnt == 0, "R8 no writes", wr_cnt, 0);
    @(negedge clk);
    chk(!busy, "R8 back to idle", busy, 0);

    // T6: boot PM page 3 offset 10, stream ends at header (R4 R6)
    new_image();
    add_w(T_PM); add_w(hdr(3, 10));
    run(1'b1, 3, 1'b1);
    chk(wr_cnt == PW - 10, "R4 empty body count", wr_cnt, PW - 10);
    chk(last_addr == PW - 1, "R6 no zero address", last_addr, PW - 1);
    for (int a = 0; a < PW; a++) begin
      logic [23:0] e;
      e = (a < 10) ? SENT : 24'h0;
      chk(pm_mem[a] == e, "R4 empty body fill", int'(pm_mem[a]), int'(e));
    end
    @(negedge clk);
    chk(!done && !busy, "R10 done one cycle", {done, busy}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule